// File: doc/BRIEF.md
# Misaligned Load/Store Splitter

This block sits between a processor's address generation step and a word-wide data memory bus. It takes one load or store of byte, halfword or word size at any byte address. If the access fits inside one aligned bus word, it issues one bus transaction. If the access runs past the end of that word, it issues two aligned transactions back to back: first the word that holds the starting byte, then the next word. The block computes byte enables and shifted write data for each beat. For loads it reassembles the bytes of the two beats, extends the result with sign or zeros, and returns one response.

The request side is a valid/ready stream. A request is taken on a clock edge where `req_valid` and `req_ready` are both high. `req_ready` is high only while no access is in flight, so the core holds a request until it is taken. The response is a single-cycle `rsp_valid` pulse without back-pressure, and the core must take it in that cycle. The bus side uses a request/grant handshake. `bus_req` stays asserted with stable fields until the edge where `bus_gnt` is sampled high. One `bus_rvalid` then follows in a later cycle, carrying `bus_rdata` and `bus_err`. An error on the first beat of a split access aborts the access. The address that failed is returned with the error response so that software can record it as the trap value.

Top module: `lsu_split`

## Requirements
- R1: `req_ready` is high and `busy` is low when idle. From the edge that takes a request, `busy` is high and `req_ready` is low until the edge that samples the last `bus_rvalid` of the access. After that edge, `busy` is low again.
- R2: Size code 0 is a byte, 1 is a halfword and 2 is a word. A byte access never splits. A halfword access splits only at address offset 3. A word access splits at offsets 1, 2 and 3. A split access makes exactly two bus transactions, and any other access makes exactly one.
- R3: The first beat's `bus_addr` is the request address with its two low bits cleared. The second beat's `bus_addr` is that value plus 4, wrapping at the top of the address space.
- R4: `bus_be` bit i enables byte lane i, which is `bus_wdata[8i+7:8i]`. A beat enables exactly those lanes that hold a byte of the access. The lanes are derived from the original address offset for both beats.
- R5: For stores, byte k of `req_wdata` appears in the lane and beat of byte address `addr+k`. `bus_we` is high for stores and low for loads.
- R6: For loads, byte k of `rsp_rdata` is the byte that the bus returned for address `addr+k`. Bytes come from the second beat when `addr+k` falls in the next word.
- R7: Load bytes above the access size are copies of the top loaded bit when `req_signed` is 1, and zero otherwise. Stores and error responses return `rsp_rdata` = 0.
- R8: An error on the first beat issues no second beat. The error response has `rsp_err`=1 and `rsp_err_addr` equal to the original request address.
- R9: An error on the second beat gives `rsp_err`=1 with `rsp_err_addr` equal to the second beat's word address. A response without error has `rsp_err`=0 and `rsp_err_addr`=0.
- R10: While `bus_req` is high and `bus_gnt` is low, `bus_req`, `bus_addr`, `bus_be`, `bus_wdata` and `bus_we` hold their values into the next cycle. `bus_req` drops after the grant.
- R11: Each request that is taken produces exactly one `rsp_valid` pulse, one cycle long. The pulse comes in the cycle after the edge that samples the last `bus_rvalid`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Access request valid |
| req_ready | output | 1 | Block can take a request |
| req_we | input | 1 | 1 = store, 0 = load |
| req_size | input | 2 | 0 byte, 1 halfword, 2 word |
| req_signed | input | 1 | Sign-extend load result |
| req_addr | input | 32 | Byte address of the access |
| req_wdata | input | 32 | Store data, least significant byte first |
| busy | output | 1 | Access in flight |
| rsp_valid | output | 1 | One-cycle response pulse |
| rsp_err | output | 1 | Access ended with a bus error |
| rsp_rdata | output | 32 | Assembled and extended load data |
| rsp_err_addr | output | 32 | Address that failed |
| bus_req | output | 1 | Bus transaction request |
| bus_gnt | input | 1 | Bus grant for the current request |
| bus_addr | output | 32 | Word-aligned bus address |
| bus_we | output | 1 | Bus write enable |
| bus_be | output | 4 | Bus byte enables |
| bus_wdata | output | 32 | Bus write data |
| bus_rvalid | input | 1 | Bus response valid |
| bus_rdata | input | 32 | Bus read data |
| bus_err | input | 1 | Bus response error |

## Verification
The bench covers every size at all four offsets, for both loads and stores. This separates single-beat accesses from split accesses and shows whether the lanes follow the original offset or the advanced address. A signed halfword load and an unsigned halfword load with the top bit set are both used, so sign extension can be told apart from zero extension. Errors are injected on the first beat, on the second beat and on a single-beat access. These three cases separate the cancel path from the late-error path and show which address is reported. Constrained random accesses with random grant and response delays then exercise the bus hold rule and the reassembly at addresses near the top of the address space.

// File: rtl/lsu_split_pkg.sv
package lsu_split_pkg;

  typedef enum logic [1:0] {
    SZ_BYTE = 2'd0,
    SZ_HALF = 2'd1,
    SZ_WORD = 2'd2
  } acc_size_e;

  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_REQ1  = 3'd1,
    ST_WAIT1 = 3'd2,
    ST_REQ2  = 3'd3,
    ST_WAIT2 = 3'd4
  } seq_state_e;

endpackage

// File: rtl/lsu_split_lane.sv
module lsu_split_lane #(
  parameter int DATA_W = 32,
  localparam int BYTES = DATA_W / 8,
  localparam int OFF_W = $clog2(BYTES)
) (
  input  logic [OFF_W-1:0]  off_i,
  input  logic [1:0]        size_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [BYTES-1:0]  be_lo_o,
  output logic [BYTES-1:0]  be_hi_o,
  output logic [DATA_W-1:0] wd_lo_o,
  output logic [DATA_W-1:0] wd_hi_o,
  output logic              split_o
);
  int unsigned          nb;
  logic [2*BYTES-1:0]   mask;
  logic [2*BYTES-1:0]   be_all;
  logic [2*DATA_W-1:0]  wd_all;

  always_comb begin
    case (size_i)
      2'd0:    nb = 1;
      2'd1:    nb = 2;
      default: nb = BYTES;
    endcase
    for (int i = 0; i < 2*BYTES; i++) begin
      mask[i] = (i < nb);
    end
    // lanes follow the original offset for both beats
    be_all = mask << off_i;
    wd_all = {{DATA_W{1'b0}}, wdata_i} << {off_i, 3'b000};
  end

  assign be_lo_o = be_all[BYTES-1:0];
  assign be_hi_o = be_all[2*BYTES-1:BYTES];
  assign wd_lo_o = wd_all[DATA_W-1:0];
  assign wd_hi_o = wd_all[2*DATA_W-1:DATA_W];
  assign split_o = |be_all[2*BYTES-1:BYTES];

endmodule

// File: rtl/lsu_split_align.sv
module lsu_split_align #(
  parameter int DATA_W = 32,
  localparam int BYTES = DATA_W / 8,
  localparam int OFF_W = $clog2(BYTES)
) (
  input  logic [OFF_W-1:0]  off_i,
  input  logic [1:0]        size_i,
  input  logic              signed_i,
  input  logic [DATA_W-1:0] lo_i,
  input  logic [DATA_W-1:0] hi_i,
  output logic [DATA_W-1:0] result_o
);
  int unsigned         nb;
  logic [2*DATA_W-1:0] shifted;
  logic                fill;

  always_comb begin
    shifted = {hi_i, lo_i} >> {off_i, 3'b000};
    case (size_i)
      2'd0: begin
        nb   = 1;
        fill = signed_i & shifted[7];
      end
      2'd1: begin
        nb   = 2;
        fill = signed_i & shifted[15];
      end
      default: begin
        nb   = BYTES;
        fill = signed_i & shifted[DATA_W-1];
      end
    endcase
    for (int i = 0; i < BYTES; i++) begin
      if (i < nb) result_o[8*i +: 8] = shifted[8*i +: 8];
      else        result_o[8*i +: 8] = {8{fill}};
    end
  end

endmodule

// File: rtl/lsu_split_seq.sv
module lsu_split_seq
  import lsu_split_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic req_valid_i,
  input  logic split_i,
  input  logic bus_gnt_i,
  input  logic bus_rvalid_i,
  input  logic bus_err_i,
  output logic req_ready_o,
  output logic busy_o,
  output logic bus_req_o,
  output logic beat2_o,
  output logic take_lo_o,
  output logic finish_o
);
  seq_state_e state_q, state_d;

  always_comb begin
    state_d = state_q;
    case (state_q)
      ST_IDLE:  if (req_valid_i) state_d = ST_REQ1;
      ST_REQ1:  if (bus_gnt_i) state_d = ST_WAIT1;
      ST_WAIT1: if (bus_rvalid_i) state_d = (bus_err_i || !split_i) ? ST_IDLE : ST_REQ2;
      ST_REQ2:  if (bus_gnt_i) state_d = ST_WAIT2;
      ST_WAIT2: if (bus_rvalid_i) state_d = ST_IDLE;
      default:  state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= ST_IDLE;
    else        state_q <= state_d;
  end

  assign req_ready_o = (state_q == ST_IDLE);
  assign busy_o      = (state_q != ST_IDLE);
  assign bus_req_o   = (state_q == ST_REQ1) || (state_q == ST_REQ2);
  assign beat2_o     = (state_q == ST_REQ2) || (state_q == ST_WAIT2);
  assign take_lo_o   = (state_q == ST_WAIT1) && bus_rvalid_i && !bus_err_i && split_i;
  assign finish_o    = ((state_q == ST_WAIT1) && bus_rvalid_i && (bus_err_i || !split_i))
                    || ((state_q == ST_WAIT2) && bus_rvalid_i);

  AST_ERR_CANCELS_BEAT2: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_WAIT1 && bus_rvalid_i && bus_err_i) |=> (!bus_req_o && !busy_o)); // R8

  AST_TAKE_STARTS_BUS: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid_i && req_ready_o) |=> (bus_req_o && busy_o && !req_ready_o)); // R1

  AST_SPLIT_GOES_BEAT2: assert property (@(posedge clk) disable iff (!rst_n)
    take_lo_o |=> (bus_req_o && beat2_o)); // R2

endmodule

// File: rtl/lsu_split.sv
module lsu_split
  import lsu_split_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32,
  localparam int BYTES = DATA_W / 8,
  localparam int OFF_W = $clog2(BYTES)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_we,
  input  logic [1:0]        req_size,
  input  logic              req_signed,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              busy,
  output logic              rsp_valid,
  output logic              rsp_err,
  output logic [DATA_W-1:0] rsp_rdata,
  output logic [ADDR_W-1:0] rsp_err_addr,
  output logic              bus_req,
  input  logic              bus_gnt,
  output logic [ADDR_W-1:0] bus_addr,
  output logic              bus_we,
  output logic [BYTES-1:0]  bus_be,
  output logic [DATA_W-1:0] bus_wdata,
  input  logic              bus_rvalid,
  input  logic [DATA_W-1:0] bus_rdata,
  input  logic              bus_err
);
  logic [ADDR_W-1:0] a_addr_q;
  logic [1:0]        a_size_q;
  logic              a_signed_q;
  logic              a_we_q;
  logic [DATA_W-1:0] a_wdata_q;
  logic [DATA_W-1:0] rd_lo_q;

  logic [BYTES-1:0]  be_lo, be_hi;
  logic [DATA_W-1:0] wd_lo, wd_hi;
  logic              split, beat2, take_lo, finish;
  logic [ADDR_W-1:0] base_addr, next_addr;
  logic [DATA_W-1:0] al_lo, al_hi, al_res;

  lsu_split_seq u_seq (
    .clk          (clk),
    .rst_n        (rst_n),
    .req_valid_i  (req_valid),
    .split_i      (split),
    .bus_gnt_i    (bus_gnt),
    .bus_rvalid_i (bus_rvalid),
    .bus_err_i    (bus_err),
    .req_ready_o  (req_ready),
    .busy_o       (busy),
    .bus_req_o    (bus_req),
    .beat2_o      (beat2),
    .take_lo_o    (take_lo),
    .finish_o     (finish)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      a_addr_q   <= '0;
      a_size_q   <= '0;
      a_signed_q <= 1'b0;
      a_we_q     <= 1'b0;
      a_wdata_q  <= '0;
    end else if (req_valid && req_ready) begin
      a_addr_q   <= req_addr;
      a_size_q   <= req_size;
      a_signed_q <= req_signed;
      a_we_q     <= req_we;
      a_wdata_q  <= req_wdata;
    end
  end

  lsu_split_lane #(.DATA_W(DATA_W)) u_lane (
    .off_i   (a_addr_q[OFF_W-1:0]),
    .size_i  (a_size_q),
    .wdata_i (a_wdata_q),
    .be_lo_o (be_lo),
    .be_hi_o (be_hi),
    .wd_lo_o (wd_lo),
    .wd_hi_o (wd_hi),
    .split_o (split)
  );

  assign base_addr = {a_addr_q[ADDR_W-1:OFF_W], {OFF_W{1'b0}}};
  assign next_addr = base_addr + ADDR_W'(BYTES);

  assign bus_addr  = beat2 ? next_addr : base_addr;
  assign bus_be    = beat2 ? be_hi : be_lo;
  assign bus_wdata = beat2 ? wd_hi : wd_lo;
  assign bus_we    = a_we_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       rd_lo_q <= '0;
    else if (take_lo) rd_lo_q <= bus_rdata;
  end

  assign al_lo = beat2 ? rd_lo_q : bus_rdata;
  assign al_hi = beat2 ? bus_rdata : '0;

  lsu_split_align #(.DATA_W(DATA_W)) u_align (
    .off_i    (a_addr_q[OFF_W-1:0]),
    .size_i   (a_size_q),
    .signed_i (a_signed_q),
    .lo_i     (al_lo),
    .hi_i     (al_hi),
    .result_o (al_res)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid    <= 1'b0;
      rsp_err      <= 1'b0;
      rsp_rdata    <= '0;
      rsp_err_addr <= '0;
    end else begin
      rsp_valid <= finish;
      if (finish) begin
        rsp_err      <= bus_err;
        rsp_rdata    <= (!a_we_q && !bus_err) ? al_res : '0;
        rsp_err_addr <= !bus_err ? '0 : (beat2 ? next_addr : a_addr_q);
      end
    end
  end

  AST_BUS_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_req && !bus_gnt) |=> (bus_req && $stable(bus_addr) && $stable(bus_be)
                               && $stable(bus_wdata) && $stable(bus_we))); // R10

  AST_ADDR_ALIGNED: assert property (@(posedge clk) disable iff (!rst_n)
    bus_req |-> (bus_addr[OFF_W-1:0] == '0)); // R3

  AST_BE_PRESENT: assert property (@(posedge clk) disable iff (!rst_n)
    bus_req |-> (bus_be != '0)); // R4

  AST_RSP_AFTER_BUS: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> ($past(bus_rvalid) && !busy)); // R11

endmodule

// File: tb/sim_lsu_split.sv
module sim_lsu_split;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic        req_we = 1'b0;
  logic [1:0]  req_size = 2'd0;
  logic        req_signed = 1'b0;
  logic [31:0] req_addr = '0;
  logic [31:0] req_wdata = '0;
  logic        busy;
  logic        rsp_valid;
  logic        rsp_err;
  logic [31:0] rsp_rdata;
  logic [31:0] rsp_err_addr;
  logic        bus_req;
  logic        bus_gnt = 1'b0;
  logic [31:0] bus_addr;
  logic        bus_we;
  logic [3:0]  bus_be;
  logic [31:0] bus_wdata;
  logic        bus_rvalid = 1'b0;
  logic [31:0] bus_rdata = '0;
  logic        bus_err = 1'b0;

  int checks = 0;
  int failures = 0;

  always #10 clk = ~clk;

  lsu_split u0 (.*);

  task automatic chk(input string req, input string what, input logic [31:0] got,
                     input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      failures++;
      $display("FAIL %s %s got=%h exp=%h", req, what, got, exp);
    end
  endtask

  function automatic logic [7:0] mem_byte(input logic [31:0] a);
    return (a[7:0] * 8'd29) ^ a[15:8] ^ a[31:24] ^ 8'h5a;
  endfunction

  function automatic logic [31:0] mem_word(input logic [31:0] wa);
    return {mem_byte(wa + 3), mem_byte(wa + 2), mem_byte(wa + 1), mem_byte(wa)};
  endfunction

  // err_beat: 0 none, 1 first beat, 2 second beat
  task automatic access(input logic we, input logic [1:0] size, input logic sgn,
                        input logic [31:0] addr, input logic [31:0] wdata, input int err_beat);
    int nb;
    int nbeats;
    logic [31:0] word0;
    logic [31:0] exp_addr [2];
    logic [3:0]  exp_be [2];
    logic [31:0] exp_wd [2];
    logic [31:0] exp_rd;
    logic        fill;
    logic        got_err;
    logic [31:0] exp_eaddr;
    nb = (size == 2'd0) ? 1 : (size == 2'd1) ? 2 : 4;
    word0 = {addr[31:2], 2'b00};
    exp_addr[0] = word0;
    exp_addr[1] = word0 + 32'd4;
    exp_be[0] = '0; exp_be[1] = '0; exp_wd[0] = '0; exp_wd[1] = '0;
    exp_rd = '0;
    nbeats = 1;
    for (int k = 0; k < nb; k++) begin
      logic [31:0] ba;
      int bt;
      ba = addr + 32'(k);
      bt = ({ba[31:2], 2'b00} == word0) ? 0 : 1;
      if (bt == 1) nbeats = 2;
      exp_be[bt][ba[1:0]] = 1'b1;
      exp_wd[bt][8*ba[1:0] +: 8] = wdata[8*k +: 8];
      exp_rd[8*k +: 8] = mem_byte(ba);
    end
    fill = sgn & exp_rd[8*nb-1];
    for (int k = nb; k < 4; k++) exp_rd[8*k +: 8] = {8{fill}};

    @(negedge clk);
    chk("R1", "idle ready", {31'b0, req_ready}, 32'd1);
    chk("R1", "idle busy", {31'b0, busy}, 32'd0);
    req_valid = 1'b1; req_we = we; req_size = size; req_signed = sgn;
    req_addr = addr; req_wdata = wdata;
    @(negedge clk);
    req_valid = 1'b0;
    req_addr = $urandom; req_wdata = $urandom; req_size = 2'($urandom);
    got_err = 1'b0;
    exp_eaddr = '0;
    for (int b = 0; b < 2; b++) begin
      int d;
      chk(b == 0 ? "R2" : "R2", "bus_req at beat start", {31'b0, bus_req}, 32'd1);
      chk("R1", "busy in flight", {31'b0, busy}, 32'd1);
      chk("R1", "ready low in flight", {31'b0, req_ready}, 32'd0);
      chk("R3", "beat address", bus_addr, exp_addr[b]);
      chk("R4", "byte enables", {28'b0, bus_be}, {28'b0, exp_be[b]});
      chk("R5", "write enable", {31'b0, bus_we}, {31'b0, we});
      if (we) chk("R5", "write data", bus_wdata & {{8{bus_be[3]}}, {8{bus_be[2]}},
                 {8{bus_be[1]}}, {8{bus_be[0]}}}, exp_wd[b]);
      d = $urandom % 3;
      repeat (d) begin
        @(negedge clk);
        chk("R10", "req held", {31'b0, bus_req}, 32'd1);
        chk("R10", "addr held", bus_addr, exp_addr[b]);
        chk("R10", "be held", {28'b0, bus_be}, {28'b0, exp_be[b]});
      end
      bus_gnt = 1'b1;
      @(negedge clk);
      bus_gnt = 1'b0;
      chk("R10", "req drops after grant", {31'b0, bus_req}, 32'd0);
      d = $urandom % 3;
      repeat (d) @(negedge clk);
      bus_rvalid = 1'b1;
      bus_rdata = mem_word(exp_addr[b]);
      bus_err = (err_beat == b + 1);
      @(negedge clk);
      bus_rvalid = 1'b0; bus_rdata = $urandom;
      if (bus_err) begin
        got_err = 1'b1;
        exp_eaddr = (b == 0) ? addr : exp_addr[1];
      end
      bus_err = 1'b0;
      if (got_err || b + 1 == nbeats) break;
    end
    chk("R11", "rsp pulse", {31'b0, rsp_valid}, 32'd1);
    chk("R1", "busy cleared", {31'b0, busy}, 32'd0);
    chk("R8", "no extra beat", {31'b0, bus_req}, 32'd0);
    chk(got_err ? (err_beat == 1 ? "R8" : "R9") : "R9", "rsp_err", {31'b0, rsp_err},
        {31'b0, got_err});
    chk(got_err ? (err_beat == 1 ? "R8" : "R9") : "R9", "err addr", rsp_err_addr, exp_eaddr);
    if (we || got_err) chk("R7", "zero rdata", rsp_rdata, 32'd0);
    else               chk("R6", "load data", rsp_rdata, exp_rd);
    @(negedge clk);
    chk("R11", "single pulse", {31'b0, rsp_valid}, 32'd0);
    chk("R8", "still no beat", {31'b0, bus_req}, 32'd0);
  endtask

  initial begin
    repeat (2000000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired (all requirements)");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    chk("R1", "reset ready", {31'b0, req_ready}, 32'd1);
    chk("R11", "reset rsp_valid", {31'b0, rsp_valid}, 32'd0);
    chk("R10", "reset bus_req", {31'b0, bus_req}, 32'd0);
    rst_n = 1'b1;
    // R2: all sizes at all offsets, loads and stores
    for (int s = 0; s < 3; s++)
      for (int o = 0; o < 4; o++) begin
        access(1'b0, 2'(s), 1'b0, 32'h0000_1230 + 32'(o), 32'h0, 0);
        access(1'b1, 2'(s), 1'b0, 32'h0000_4560 + 32'(o), 32'hA1B2_C3D4, 0);
      end
    // R7: signed vs unsigned halfword with top bit set (mem_byte chosen per address)
    for (int a = 0; a < 8; a++) begin
      access(1'b0, 2'd1, 1'b1, 32'h0000_0700 + 32'(a), 32'h0, 0);
      access(1'b0, 2'd1, 1'b0, 32'h0000_0700 + 32'(a), 32'h0, 0);
      access(1'b0, 2'd0, 1'b1, 32'h0000_0700 + 32'(a), 32'h0, 0);
    end
    // R8: first-beat error cancels second beat
    access(1'b0, 2'd2, 1'b0, 32'h0000_2003, 32'h0, 1);
    access(1'b1, 2'd1, 1'b0, 32'h0000_2007, 32'h1122_3344, 1);
    // R9: second-beat error, and single-beat error
    access(1'b0, 2'd2, 1'b1, 32'h0000_3002, 32'h0, 2);
    access(1'b1, 2'd2, 1'b0, 32'h0000_3001, 32'h5566_7788, 2);
    access(1'b0, 2'd2, 1'b0, 32'h0000_3004, 32'h0, 1);
    // R3: wrap at top of address space
    access(1'b0, 2'd2, 1'b0, 32'hFFFF_FFFE, 32'h0, 0);
    for (int i = 0; i < 400; i++) begin
      logic [1:0] sz;
      int eb;
      sz = 2'($urandom % 3);
      eb = (($urandom % 8) == 0) ? int'(1 + $urandom % 2) : 0;
      access(1'($urandom), sz, 1'($urandom), $urandom, $urandom, eb);
    end
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule